// File: doc/BRIEF.md
# Host-to-Firmware Mailbox Doorbell Controller

This block gives a host a set of mailboxes through which it can post short messages to local firmware. Each mailbox is eight bytes wide and sits in its own 64 KB-aligned slice of the host address space, so any single mailbox can be handed to user code without exposing the others. When the host writes into a mailbox, the data lands in internal storage and the mailbox is flagged as pending. Pending flags gated by per-mailbox enables drive one interrupt line toward the local processor.

Firmware reaches the block through a small 32-bit register port. It reads mailbox contents a word at a time, reads and writes the enable mask, clears pending flags with a write-one-to-clear register, and reads a priority register that names the lowest-numbered mailbox that is both pending and enabled. Host writes carry byte enables and a per-transaction byte-swap flag. Writes aimed past the eight-byte window inside a mailbox slice are dropped.

Top module: `mbox_doorbell_ctrl`

## Requirements
- R1: After synchronous reset, every pending bit and every enable bit is 0, irq is 0, and the priority register reads 0.
- R2: A host write with address offset bits [15:3] all zero targets the mailbox selected by host_addr[20:16]. It stores only the byte lanes whose enable bit is 1 and leaves the other lanes unchanged. Address bits [2:0] are ignored.
- R3: With host_swap at 1, input byte lane i (data bits [8i+7:8i] and host_be[i]) is stored in mailbox byte 7-i. With host_swap at 0, lane i goes to byte i.
- R4: Every host write inside the window sets that mailbox's pending bit, whatever the byte enables are, including all zero.
- R5: A host write with any of offset bits [15:3] nonzero changes neither storage nor any pending bit.
- R6: A firmware write to word address 64 clears each pending bit whose data bit is 1. Bits written as 0 have no effect.
- R7: If a host write and a clear reach the same mailbox in the same cycle, that pending bit is 1 afterwards.
- R8: Word address 65 is the enable mask (bit m enables mailbox m). It is read/write.
- R9: irq equals the OR over all mailboxes of pending AND enable. It changes on the same clock edge as the flags that cause the change.
- R10: Word address 66 reads bit 31 as a valid flag and bits [4:0] as the index of the lowest-numbered mailbox that is both pending and enabled. It reads all zero when no such mailbox exists.
- R11: Firmware read data appears on fw_rdata one clock edge after fw_addr is presented. Word address 2m returns mailbox m bytes 0..3 (byte 0 in bits [7:0]). Word address 2m+1 returns bytes 4..7. Word address 64 returns the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 21 | Host byte address: [20:16] mailbox, [15:0] offset |
| host_data | input | 64 | Host write data, byte lane i in bits [8i+7:8i] |
| host_be | input | 8 | Host byte enables, one per lane |
| host_swap | input | 1 | Reverse byte lanes for this write |
| fw_we | input | 1 | Firmware register write strobe |
| fw_addr | input | 7 | Firmware word address |
| fw_wdata | input | 32 | Firmware write data |
| fw_rdata | output | 32 | Firmware read data, one cycle after address |
| irq | output | 1 | Doorbell interrupt to local processor |

## Verification
The hardest case to reach is a host write and a firmware clear that hit the same pending bit on the same clock edge, because the two ports are normally driven by unrelated agents. The bench drives both strobes in one cycle, both as a directed case and as a recurring random operation, and then reads back the pending register. Swapped partial writes are a second case that random host traffic seldom covers in a checkable way. These are driven directly with single-lane enables so that the mirrored destination byte can be checked in isolation.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Offsets of the control words above the mailbox data area
  typedef enum logic [1:0] {
    CR_PEND = 2'd0,
    CR_EN   = 2'd1,
    CR_LOW  = 2'd2,
    CR_NONE = 2'd3
  } ctrl_sel_e;

endpackage

// File: rtl/mbx_hostdec.sv
module mbx_hostdec #(
  parameter int NUM_MBOX    = 32,
  parameter int MBOX_BYTES  = 8,
  parameter int STRIDE_BITS = 16,
  localparam int IDX_W   = $clog2(NUM_MBOX),
  localparam int LANE_W  = $clog2(MBOX_BYTES),
  localparam int DATA_W  = MBOX_BYTES * 8,
  localparam int HADDR_W = STRIDE_BITS + IDX_W
) (
  input  logic                  host_we,
  input  logic [HADDR_W-1:0]    host_addr,
  input  logic [DATA_W-1:0]     host_data,
  input  logic [MBOX_BYTES-1:0] host_be,
  input  logic                  host_swap,
  output logic                  in_win,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [DATA_W-1:0]     lane_data,
  output logic [MBOX_BYTES-1:0] lane_be,
  output logic [NUM_MBOX-1:0]   set_vec
);

  // offset bits above the byte lane must all be zero
  assign in_win = (host_addr[STRIDE_BITS-1:LANE_W] == '0);
  assign wr_idx = host_addr[STRIDE_BITS +: IDX_W];
  assign wr_en  = host_we & in_win;

  always_comb begin
    set_vec = '0;
    if (wr_en) set_vec[wr_idx] = 1'b1;
  end

  // per-lane steering, mirrored when swap is requested
  for (genvar g = 0; g < MBOX_BYTES; g++) begin : g_lane
    localparam int MIR = MBOX_BYTES - 1 - g;
    assign lane_data[g*8 +: 8] = host_swap ? host_data[MIR*8 +: 8] : host_data[g*8 +: 8];
    assign lane_be[g]          = host_swap ? host_be[MIR] : host_be[g];
  end

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int NUM_MBOX   = 32,
  parameter int MBOX_BYTES = 8,
  parameter int FW_DW      = 32,
  localparam int IDX_W     = $clog2(NUM_MBOX),
  localparam int DATA_W    = MBOX_BYTES * 8,
  localparam int WORDS_PER = DATA_W / FW_DW,
  localparam int WSEL_W    = $clog2(WORDS_PER)
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [MBOX_BYTES-1:0] wr_be,
  input  logic [IDX_W-1:0]      rd_row,
  input  logic [WSEL_W-1:0]     rd_word,
  output logic [FW_DW-1:0]      rd_data
);

  logic [DATA_W-1:0] mem [NUM_MBOX];
  logic [DATA_W-1:0] row_q;
  logic [WSEL_W-1:0] word_q;

  // byte-enabled write port, no reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < MBOX_BYTES; b++) begin
        if (wr_be[b]) mem[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  // registered read of a full row, word picked after the register
  always_ff @(posedge clk) begin
    row_q  <= mem[rd_row];
    word_q <= rd_word;
  end

  assign rd_data = row_q[word_q*FW_DW +: FW_DW];

endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
  parameter int NUM_MBOX = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_MBOX-1:0] set_vec,
  input  logic                clr_we,
  input  logic [NUM_MBOX-1:0] clr_mask,
  input  logic                en_we,
  input  logic [NUM_MBOX-1:0] en_data,
  output logic [NUM_MBOX-1:0] pend_o,
  output logic [NUM_MBOX-1:0] en_o,
  output logic                irq_o
);

  logic [NUM_MBOX-1:0] pend_q, en_q, pend_d, en_d;
  logic                irq_q;

  // set is applied after clear so a same-cycle hit stays pending
  always_comb begin
    pend_d = pend_q;
    if (clr_we) pend_d = pend_d & ~clr_mask;
    pend_d = pend_d | set_vec;
    en_d   = en_we ? en_data : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= |(pend_d & en_d);
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R6
  clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && set_vec == '0) |=> ((pend_q & $past(clr_mask)) == '0));

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(pend_q & en_q));

endmodule

// File: rtl/mbx_lowest.sv
module mbx_lowest #(
  parameter int NUM_MBOX = 32,
  localparam int IDX_W = $clog2(NUM_MBOX)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_MBOX-1:0] vec,
  output logic                valid,
  output logic [IDX_W-1:0]    idx
);

  // scan from the top so the lowest set bit is the last one kept
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = NUM_MBOX - 1; i >= 0; i--) begin
      if (vec[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R10
  low_hit_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> vec[idx]);

  // R10
  low_first_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((vec & ((NUM_MBOX'(1) << idx) - NUM_MBOX'(1))) == '0));

  // R10
  low_none_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (vec == '0));

endmodule

// File: rtl/mbox_doorbell_ctrl.sv
module mbox_doorbell_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_MBOX    = 32,
  parameter int MBOX_BYTES  = 8,
  parameter int STRIDE_BITS = 16,
  parameter int FW_DW       = 32,
  localparam int IDX_W      = $clog2(NUM_MBOX),
  localparam int DATA_W     = MBOX_BYTES * 8,
  localparam int HADDR_W    = STRIDE_BITS + IDX_W,
  localparam int WORDS_PER  = DATA_W / FW_DW,
  localparam int WSEL_W     = $clog2(WORDS_PER),
  localparam int DATA_AW    = $clog2(NUM_MBOX * WORDS_PER),
  localparam int FW_AW      = DATA_AW + 1,
  localparam int CTRL_BASE  = 2 ** DATA_AW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_we,
  input  logic [HADDR_W-1:0]    host_addr,
  input  logic [DATA_W-1:0]     host_data,
  input  logic [MBOX_BYTES-1:0] host_be,
  input  logic                  host_swap,
  input  logic                  fw_we,
  input  logic [FW_AW-1:0]      fw_addr,
  input  logic [FW_DW-1:0]      fw_wdata,
  output logic [FW_DW-1:0]      fw_rdata,
  output logic                  irq
);

  logic                  in_win, wr_en;
  logic [IDX_W-1:0]      wr_idx;
  logic [DATA_W-1:0]     lane_data;
  logic [MBOX_BYTES-1:0] lane_be;
  logic [NUM_MBOX-1:0]   set_vec, pend, en;
  logic                  low_valid;
  logic [IDX_W-1:0]      low_idx;
  logic [FW_DW-1:0]      mbox_word;
  logic                  in_data_area, area_q;
  ctrl_sel_e             csel;
  logic [FW_DW-1:0]      ctrl_q;

  mbx_hostdec #(.NUM_MBOX(NUM_MBOX), .MBOX_BYTES(MBOX_BYTES), .STRIDE_BITS(STRIDE_BITS)) u_dec (
    .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
    .host_be(host_be), .host_swap(host_swap), .in_win(in_win), .wr_en(wr_en),
    .wr_idx(wr_idx), .lane_data(lane_data), .lane_be(lane_be), .set_vec(set_vec)
  );

  mbx_store #(.NUM_MBOX(NUM_MBOX), .MBOX_BYTES(MBOX_BYTES), .FW_DW(FW_DW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(lane_data), .wr_be(lane_be),
    .rd_row(fw_addr[WSEL_W +: IDX_W]), .rd_word(fw_addr[WSEL_W-1:0]), .rd_data(mbox_word)
  );

  // control word decode
  assign in_data_area = ~fw_addr[FW_AW-1];
  always_comb begin
    if (fw_addr == FW_AW'(CTRL_BASE))          csel = CR_PEND;
    else if (fw_addr == FW_AW'(CTRL_BASE + 1)) csel = CR_EN;
    else if (fw_addr == FW_AW'(CTRL_BASE + 2)) csel = CR_LOW;
    else                                       csel = CR_NONE;
  end

  mbx_flags #(.NUM_MBOX(NUM_MBOX)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .clr_we(fw_we && csel == CR_PEND), .clr_mask(fw_wdata[NUM_MBOX-1:0]),
    .en_we(fw_we && csel == CR_EN), .en_data(fw_wdata[NUM_MBOX-1:0]),
    .pend_o(pend), .en_o(en), .irq_o(irq)
  );

  mbx_lowest #(.NUM_MBOX(NUM_MBOX)) u_low (
    .clk(clk), .rst(rst), .vec(pend & en), .valid(low_valid), .idx(low_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      area_q <= 1'b0;
    end else begin
      area_q <= in_data_area;
      unique case (csel)
        CR_PEND: ctrl_q <= FW_DW'(pend);
        CR_EN:   ctrl_q <= FW_DW'(en);
        CR_LOW:  ctrl_q <= {low_valid, (FW_DW-1-IDX_W)'(0), low_idx};
        default: ctrl_q <= '0;
      endcase
    end
  end

  assign fw_rdata = area_q ? mbox_word : ctrl_q;

  // R5
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && !in_win) |=> ((pend & ~$past(pend)) == '0));

  // R4
  hit_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && in_win) |=> pend[$past(wr_idx)]);

endmodule

// File: tb/sim_mbox_doorbell_ctrl.sv
module sim_mbox_doorbell_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [20:0] host_addr = '0;
  logic [63:0] host_data = '0;
  logic [7:0]  host_be = '0;
  logic        host_swap = 1'b0;
  logic        fw_we = 1'b0;
  logic [6:0]  fw_addr = '0;
  logic [31:0] fw_wdata = '0;
  logic [31:0] fw_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] m_mem [NM];
  logic [31:0] m_pend = '0;
  logic [31:0] m_en = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_doorbell_ctrl u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_data(host_data), .host_be(host_be), .host_swap(host_swap),
    .fw_we(fw_we), .fw_addr(fw_addr), .fw_wdata(fw_wdata),
    .fw_rdata(fw_rdata), .irq(irq)
  );

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_low();
    logic [31:0] v = m_pend & m_en;
    for (int i = NM - 1; i >= 0; i--)
      if (v[i]) exp_low = {1'b1, 26'd0, i[4:0]};
    if (v == 0) exp_low = '0;
  endfunction

  function automatic void model_host(int idx, logic [15:0] off, logic [63:0] d,
                                     logic [7:0] be, bit sw);
    if (off[15:3] == 0) begin
      for (int b = 0; b < 8; b++) begin
        int ln = sw ? 7 - b : b;
        if (be[b]) m_mem[idx][ln*8 +: 8] = d[b*8 +: 8];
      end
      m_pend[idx] = 1'b1;
    end
  endfunction

  task automatic drive_host(int idx, logic [15:0] off, logic [63:0] d,
                            logic [7:0] be, bit sw);
    host_addr = {idx[4:0], off};
    host_data = d;
    host_be   = be;
    host_swap = sw;
    host_we   = 1'b1;
  endtask

  task automatic host_wr(int idx, logic [15:0] off, logic [63:0] d,
                         logic [7:0] be, bit sw);
    drive_host(idx, off, d, be, sw);
    @(negedge clk);
    host_we = 1'b0;
    model_host(idx, off, d, be, sw);
    check("R9 irq after host write", irq, |(m_pend & m_en));
  endtask

  task automatic fw_wr(logic [6:0] a, logic [31:0] d);
    fw_addr = a; fw_wdata = d; fw_we = 1'b1;
    @(negedge clk);
    fw_we = 1'b0;
    if (a == 7'd64) m_pend &= ~d;
    if (a == 7'd65) m_en = d;
    check("R9 irq after fw write", irq, |(m_pend & m_en));
  endtask

  task automatic fw_rd(logic [6:0] a, output logic [31:0] d);
    fw_addr = a;
    @(negedge clk);
    d = fw_rdata;
  endtask

  task automatic check_mbox(int idx, string tag);
    logic [31:0] d;
    fw_rd(7'(2*idx), d);
    check(tag, d, m_mem[idx][31:0]);
    fw_rd(7'(2*idx+1), d);
    check(tag, d, m_mem[idx][63:32]);
  endtask

  task automatic check_ctrl();
    logic [31:0] d;
    fw_rd(7'd64, d); check("R6 pending readback", d, m_pend);
    fw_rd(7'd65, d); check("R8 enable readback", d, m_en);
    fw_rd(7'd66, d); check("R10 lowest register", d, exp_low());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq at reset", irq, 1'b0);
    fw_rd(7'd64, d); check("R1 pending at reset", d, 32'd0);
    fw_rd(7'd65, d); check("R1 enable at reset", d, 32'd0);
    fw_rd(7'd66, d); check("R1 lowest at reset", d, 32'd0);

    // R2 R11 fill every mailbox, then read back by word
    for (int i = 0; i < NM; i++) begin
      m_mem[i] = '0;
      host_wr(i, 16'h0000, {$urandom, $urandom}, 8'hFF, 1'b0);
    end
    for (int i = 0; i < NM; i++) check_mbox(i, "R2 R11 full write");
    fw_rd(7'd64, d); check("R11 pending word", d, 32'hFFFF_FFFF);

    // R6 zero mask clears nothing, then clear everything
    fw_wr(7'd64, 32'd0);
    check_ctrl();
    fw_wr(7'd64, 32'hFFFF_FFFF);
    check_ctrl();

    // R8 enable read/write
    fw_wr(7'd65, 32'hA5A5_0F0F);
    check_ctrl();

    // R2 partial lanes, ignored low address bits
    host_wr(3, 16'h0005, 64'h1122_3344_5566_7788, 8'b0101_0010, 1'b0);
    check_mbox(3, "R2 partial lanes");

    // R3 swap: lane 0 goes to byte 7, lane 6 to byte 1
    host_wr(7, 16'h0000, 64'h00EE_0000_0000_00AB, 8'b0100_0001, 1'b1);
    check_mbox(7, "R3 swapped lanes");

    // R4 empty byte enables still set pending
    fw_wr(7'd64, 32'hFFFF_FFFF);
    host_wr(5, 16'h0000, 64'hDEAD_BEEF_DEAD_BEEF, 8'h00, 1'b0);
    check_mbox(5, "R4 data untouched");
    check_ctrl();

    // R5 outside the window
    host_wr(9, 16'h0008, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0);
    host_wr(9, 16'h8000, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b1);
    check_mbox(9, "R5 storage unchanged");
    fw_rd(7'd64, d); check("R5 no pending from miss", d, m_pend);

    // R7 clear and set on the same edge
    fw_wr(7'd65, 32'hFFFF_FFFF);
    drive_host(12, 16'h0000, 64'h1, 8'h01, 1'b0);
    fw_addr = 7'd64; fw_wdata = 32'hFFFF_FFFF; fw_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0; fw_we = 1'b0;
    m_pend = '0;
    model_host(12, 16'h0000, 64'h1, 8'h01, 1'b0);
    check("R7 irq after collision", irq, 1'b1);
    fw_rd(7'd64, d); check("R7 set beats clear", d, 32'h0000_1000);
    fw_rd(7'd66, d); check("R10 lowest after collision", d, {1'b1, 26'd0, 5'd12});

    // R10 lowest skips disabled pending mailboxes
    host_wr(2, 16'h0000, 64'h0, 8'h00, 1'b0);
    fw_wr(7'd65, 32'hFFFF_FFFB);
    check_ctrl();
    fw_wr(7'd65, 32'h0);
    check("R9 irq low when all disabled", irq, 1'b0);

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 8);
      int idx = int'($urandom % NM);
      if (op < 4) begin
        logic [15:0] off = ($urandom % 4 == 0) ? (16'h0008 | 16'($urandom))
                                               : 16'($urandom % 8);
        host_wr(idx, off, {$urandom, $urandom}, 8'($urandom), 1'($urandom));
      end else if (op == 4) begin
        fw_wr(7'd64, $urandom);
      end else if (op == 5) begin
        fw_wr(7'd65, $urandom);
      end else if (op == 6) begin
        logic [31:0] msk = $urandom | (32'd1 << idx);
        drive_host(idx, 16'h0000, {$urandom, $urandom}, 8'($urandom), 1'($urandom));
        fw_addr = 7'd64; fw_wdata = msk; fw_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0; fw_we = 1'b0;
        m_pend &= ~msk;
        model_host(idx, 16'h0000, host_data, host_be, host_swap);
        check("R7 random collision irq", irq, |(m_pend & m_en));
      end else begin
        check_mbox(idx, "R2 random readback");
      end
      check_ctrl();
    end
    for (int i = 0; i < NM; i++) check_mbox(i, "R2 R3 final contents");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule